// File: doc/BRIEF.md
# Shared External Interrupt Controller

The controller collects a parameterized set of external interrupt lines (up to 256) and turns them into per-pin interrupt requests for a core, a non-maskable request, an auxiliary special-destination request and a vector number. Each line can be sensitive to a level or to an edge. A polarity bit selects active-high/rising or active-low/falling, and a dual-edge bit lets an edge line respond to both transitions. Each input passes through a synchronizer before the controller uses it.

Software works through a simple register port with 32-bit words. Per-line arrays hold 32 lines per word. Enables are changed through separate set and clear arrays and read back from a read-only array. A read-only array shows the pending state of every line. Latched edges are set or cleared by interrupt number through a single command word. Each line has its own routing word, which sends it to a core pin and/or to the special outputs. The vector output names the highest requesting pin plus one.

Top module: `ext_irq_ctrl`

Byte map. Each per-line array spans 0x40 bytes, and word w holds lines 32w..32w+31:

| Array | Base |
|---|---|
| polarity | 0x000 |
| trigger | 0x040 |
| dual-edge | 0x080 |
| enable-clear | 0x0C0 |
| enable-set | 0x100 |
| enable (read-only) | 0x140 |
| pending (read-only) | 0x180 |

Other addresses:
- The edge command word is at 0x1C0.
- The routing word of line n is at 0x400 + 4n.

## Requirements
- R1: After reset, the polarity, trigger, dual-edge, enable and routing state is all zero, and irq_o, nmi_o, aux_o and vec_o are all zero.
- R2: Line n occupies word n/32 at bit n mod 32 of every per-line array, using the byte map above. A write whose address has bits 1:0 nonzero is ignored.
- R3: A level line (trigger bit 0) is pending while its synchronized input equals its polarity bit (1 = active high, 0 = active low). A change at irq_i shows in the pending array two clock edges later.
- R4: An edge line (trigger bit 1, dual-edge bit 0) latches pending on a rising input when polarity is 1, and on a falling input when polarity is 0. The latch holds after the input returns.
- R5: An edge line whose dual-edge bit is 1 latches pending on both rising and falling input transitions.
- R6: The edge command word works as follows:
  - A write with bit 31 = 1 sets the latch of the line numbered by bits 7:0.
  - A write with bit 31 = 0 clears that latch.
  - Numbers of NUM_LINES or more change no line.
  - A detected edge in the same cycle wins over a clear.
  - The edge command word reads as 0.
- R7: Writing 1s to an enable-set word enables those lines, and writing 1s to an enable-clear word disables them. Zero bits change nothing. The enable array reads back the current enables (1 = enabled).
- R8: Writes to the enable and pending arrays are ignored.
- R9: The routing word layout is:
  - bit 31 routes to a core pin;
  - bit 30 routes to nmi_o;
  - bit 29 routes to aux_o;
  - bits 5:0 give the pin number;
  - other bits read as 0.

  irq_o[p] is the OR over enabled pending lines that are routed to core pin p. A pin number of NUM_PINS or more drives no pin, and the pin field has no effect without bit 31.
- R10: vec_o is the highest requesting pin number plus one, and 0 when no pin is requested. It depends only on pin numbers, so the lowest-numbered line wins a tie without changing the value.
- R11: A disabled line drives no output, but it still shows in the pending array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_LINES | Raw external interrupt lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 11 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from reg_addr_i) |
| irq_o | output | NUM_PINS | Per-pin interrupt requests |
| nmi_o | output | 1 | Non-maskable request |
| aux_o | output | 1 | Auxiliary special-destination request |
| vec_o | output | 7 | Highest requesting pin plus one, 0 if none |

## Verification
The assertions take the following for granted:
- NUM_LINES is at least 32, so the first enable word is fully populated.
- A write to the edge command word names an edge-triggered line whenever its effect is checked.
- Register writes are single-cycle strobes with a stable address.

The bench keeps to these assumptions:
- It drives writes and input changes only at falling clock edges, one strobe per write.
- It configures a line's trigger bit before it issues edge commands for that line.
- It waits at least four cycles after each input change before sampling, so the synchronizer latency never decides a result, except in the latency check itself.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 11;
  localparam int unsigned VEC_W  = 7;

  // region field addr[9:6] for per-line arrays
  localparam logic [3:0] RG_POL   = 4'd0;
  localparam logic [3:0] RG_TRIG  = 4'd1;
  localparam logic [3:0] RG_DUAL  = 4'd2;
  localparam logic [3:0] RG_ENCLR = 4'd3;
  localparam logic [3:0] RG_ENSET = 4'd4;
  localparam logic [3:0] RG_EN    = 4'd5;
  localparam logic [3:0] RG_PEND  = 4'd6;

  localparam logic [ADDR_W-1:0] OFS_POL   = 11'h000;
  localparam logic [ADDR_W-1:0] OFS_TRIG  = 11'h040;
  localparam logic [ADDR_W-1:0] OFS_DUAL  = 11'h080;
  localparam logic [ADDR_W-1:0] OFS_ENCLR = 11'h0C0;
  localparam logic [ADDR_W-1:0] OFS_ENSET = 11'h100;
  localparam logic [ADDR_W-1:0] OFS_EN    = 11'h140;
  localparam logic [ADDR_W-1:0] OFS_PEND  = 11'h180;
  localparam logic [ADDR_W-1:0] OFS_EDGE  = 11'h1C0;
  localparam logic [ADDR_W-1:0] OFS_ROUTE = 11'h400;

  typedef struct packed {
    logic       core;
    logic       nmi;
    logic       aux;
    logic [5:0] pin;
  } route_t;

  function automatic logic [REG_W-1:0] route_word(route_t r);
    return {r.core, r.nmi, r.aux, 23'd0, r.pin};
  endfunction
endpackage

// File: rtl/ext_irq_line.sv
module ext_irq_line #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic pol_i,
  input  logic trig_i,
  input  logic dual_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  output logic pend_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q, latch_q;
  logic s, rise, fall, hit;

  always_comb begin
    s    = sync_q[SYNC_STAGES-1];
    rise = s & ~prev_q;
    fall = ~s & prev_q;
    hit  = trig_i & (dual_i ? (rise | fall) : (pol_i ? rise : fall));
    pend_o = trig_i ? latch_q : (s == pol_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      prev_q <= s;
      // hardware edge and software set win over clear
      if (hit || sw_set_i)  latch_q <= 1'b1;
      else if (sw_clr_i)    latch_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [REG_W-1:0]     wdata_i,
  input  logic [NUM_LINES-1:0] pend_i,
  output logic [REG_W-1:0]     rdata_o,
  output logic [NUM_LINES-1:0] pol_o,
  output logic [NUM_LINES-1:0] trig_o,
  output logic [NUM_LINES-1:0] dual_o,
  output logic [NUM_LINES-1:0] en_o,
  output route_t               route_o [NUM_LINES],
  output logic [NUM_LINES-1:0] sw_set_o,
  output logic [NUM_LINES-1:0] sw_clr_o
);
  logic       aligned, arr_hit, route_hit, edge_hit, wr_ok;
  logic [3:0] region, word_sel;
  logic [7:0] route_idx, edge_num;

  logic [NUM_LINES-1:0] pol_q, trig_q, dual_q, en_q;
  route_t               route_q [NUM_LINES];

  always_comb begin
    aligned   = (addr_i[1:0] == 2'b00);
    arr_hit   = ~addr_i[10];
    route_hit = addr_i[10];
    region    = addr_i[9:6];
    word_sel  = addr_i[5:2];
    route_idx = addr_i[9:2];
    wr_ok     = we_i & aligned;
    edge_hit  = wr_ok & (addr_i == OFS_EDGE);
    edge_num  = wdata_i[7:0];
  end

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      sw_set_o[i] = edge_hit & wdata_i[31]  & (edge_num == 8'(i));
      sw_clr_o[i] = edge_hit & ~wdata_i[31] & (edge_num == 8'(i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q  <= '0;
      trig_q <= '0;
      dual_q <= '0;
      en_q   <= '0;
      for (int i = 0; i < NUM_LINES; i++) route_q[i] <= '0;
    end else if (wr_ok) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (arr_hit && word_sel == 4'(i / 32)) begin
          case (region)
            RG_POL:   pol_q[i]  <= wdata_i[i % 32];
            RG_TRIG:  trig_q[i] <= wdata_i[i % 32];
            RG_DUAL:  dual_q[i] <= wdata_i[i % 32];
            RG_ENSET: if (wdata_i[i % 32]) en_q[i] <= 1'b1;
            RG_ENCLR: if (wdata_i[i % 32]) en_q[i] <= 1'b0;
            default: ;
          endcase
        end
        if (route_hit && route_idx == 8'(i))
          route_q[i] <= '{core: wdata_i[31], nmi: wdata_i[30],
                          aux: wdata_i[29], pin: wdata_i[5:0]};
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (aligned && route_hit) begin
      for (int i = 0; i < NUM_LINES; i++)
        if (route_idx == 8'(i)) rdata_o = route_word(route_q[i]);
    end else if (aligned) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (word_sel == 4'(i / 32)) begin
          case (region)
            RG_POL:  rdata_o[i % 32] = pol_q[i];
            RG_TRIG: rdata_o[i % 32] = trig_q[i];
            RG_DUAL: rdata_o[i % 32] = dual_q[i];
            RG_EN:   rdata_o[i % 32] = en_q[i];
            RG_PEND: rdata_o[i % 32] = pend_i[i];
            default: ;
          endcase
        end
      end
    end
  end

  assign pol_o  = pol_q;
  assign trig_o = trig_q;
  assign dual_o = dual_q;
  assign en_o   = en_q;
  always_comb for (int i = 0; i < NUM_LINES; i++) route_o[i] = route_q[i];
endmodule

// File: rtl/ext_irq_router.sv
module ext_irq_router
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned NUM_PINS  = 6
) (
  input  logic [NUM_LINES-1:0] act_i,
  input  route_t               route_i [NUM_LINES],
  output logic [NUM_PINS-1:0]  irq_o,
  output logic                 nmi_o,
  output logic                 aux_o,
  output logic [VEC_W-1:0]     vec_o
);
  always_comb begin
    irq_o = '0;
    nmi_o = 1'b0;
    aux_o = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (act_i[i]) begin
        nmi_o = nmi_o | route_i[i].nmi;
        aux_o = aux_o | route_i[i].aux;
        if (route_i[i].core)
          for (int p = 0; p < NUM_PINS; p++)
            if (route_i[i].pin == 6'(p)) irq_o[p] = 1'b1;
      end
    end
  end

  // ascending scan: last hit is the highest pin
  always_comb begin
    vec_o = '0;
    for (int p = 0; p < NUM_PINS; p++)
      if (irq_o[p]) vec_o = VEC_W'(p + 1);
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 64,
  parameter int unsigned NUM_PINS    = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  output logic [REG_W-1:0]     reg_rdata_o,
  output logic [NUM_PINS-1:0]  irq_o,
  output logic                 nmi_o,
  output logic                 aux_o,
  output logic [VEC_W-1:0]     vec_o
);
  logic [NUM_LINES-1:0] pol_w, trig_w, dual_w, en_w, pend_w, set_w, clr_w;
  route_t               route_w [NUM_LINES];

  ext_irq_regs #(.NUM_LINES(NUM_LINES)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .pend_i   (pend_w),
    .rdata_o  (reg_rdata_o),
    .pol_o    (pol_w),
    .trig_o   (trig_w),
    .dual_o   (dual_w),
    .en_o     (en_w),
    .route_o  (route_w),
    .sw_set_o (set_w),
    .sw_clr_o (clr_w)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    ext_irq_line #(.SYNC_STAGES(SYNC_STAGES)) i_line (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .raw_i    (irq_i[g]),
      .pol_i    (pol_w[g]),
      .trig_i   (trig_w[g]),
      .dual_i   (dual_w[g]),
      .sw_set_i (set_w[g]),
      .sw_clr_i (clr_w[g]),
      .pend_o   (pend_w[g])
    );
  end

  ext_irq_router #(.NUM_LINES(NUM_LINES), .NUM_PINS(NUM_PINS)) i_router (
    .act_i   (pend_w & en_w),
    .route_i (route_w),
    .irq_o   (irq_o),
    .nmi_o   (nmi_o),
    .aux_o   (aux_o),
    .vec_o   (vec_o)
  );
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned NUM_PINS  = 6
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 reg_we_i,
  input logic [ADDR_W-1:0]    reg_addr_i,
  input logic [REG_W-1:0]     reg_wdata_i,
  input logic [NUM_PINS-1:0]  irq_o,
  input logic                 nmi_o,
  input logic                 aux_o,
  input logic [VEC_W-1:0]     vec_o,
  input logic [NUM_LINES-1:0] en_w,
  input logic [NUM_LINES-1:0] pend_w,
  input logic [NUM_LINES-1:0] trig_w
);
  localparam int unsigned LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  assert_vec_tracks_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_o != '0) == (irq_o != '0));

  assert_vec_is_top_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_o != '0) |-> ((irq_o >> (vec_o - VEC_W'(1))) == NUM_PINS'(1)));

  assert_masked_silent_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o != '0) || nmi_o || aux_o) |-> ((en_w & pend_w) != '0));

  assert_edge_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFS_EDGE && reg_wdata_i[31] &&
     int'(reg_wdata_i[7:0]) < NUM_LINES && trig_w[reg_wdata_i[LW-1:0]])
    |=> pend_w[$past(reg_wdata_i[LW-1:0])]);

  assert_en_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFS_ENSET)
    |=> ((en_w[31:0] & $past(reg_wdata_i)) == $past(reg_wdata_i)));

  assert_en_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFS_ENCLR)
    |=> ((en_w[31:0] & $past(reg_wdata_i)) == '0));
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.NUM_LINES(NUM_LINES), .NUM_PINS(NUM_PINS)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .nmi_o       (nmi_o),
  .aux_o       (aux_o),
  .vec_o       (vec_o),
  .en_w        (en_w),
  .pend_w      (pend_w),
  .trig_w      (trig_w)
);

// File: tb/test_ext_irq_ctrl.sv
`timescale 1ns/1ps
module test_ext_irq_ctrl;
  localparam int N = 64;
  localparam int P = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic        we = 1'b0;
  logic [10:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [P-1:0] irq_out;
  logic        nmi, aux;
  logic [6:0]  vec;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ext_irq_ctrl #(.NUM_LINES(N), .NUM_PINS(P)) i_ext_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq_in),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq_out), .nmi_o(nmi), .aux_o(aux), .vec_o(vec)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    #1;
  endtask

  task automatic chk_out(input string tag, input logic [P-1:0] ei, input logic [6:0] ev,
                         input logic en, input logic ea);
    #1;
    check({tag, " irq"}, 32'(irq_out), 32'(ei));
    check({tag, " vec"}, 32'(vec), 32'(ev));
    check({tag, " nmi"}, 32'(nmi), 32'(en));
    check({tag, " aux"}, 32'(aux), 32'(ea));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(11'h000, d); check("R1 pol reset", d, 0);
    rd(11'h040, d); check("R1 trig reset", d, 0);
    rd(11'h080, d); check("R1 dual reset", d, 0);
    rd(11'h140, d); check("R1 en w0 reset", d, 0);
    rd(11'h144, d); check("R1 en w1 reset", d, 0);
    rd(11'h414, d); check("R1 route reset", d, 0);
    chk_out("R1 outputs", '0, 0, 0, 0);
    // active-low level lines with inputs low are pending
    rd(11'h180, d); check("R3 active-low pending", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(11'h004, 32'h0000_0020);       // line 37: word1 bit5 active high
    settle();
    rd(11'h184, d); check("R2 R3 line37 idle", d, 32'hFFFF_FFDF);
    @(negedge clk); irq_in[37] = 1'b1;
    @(negedge clk); #1 addr = 11'h184; #1;
    check("R3 latency one edge", rdata, 32'hFFFF_FFDF);
    @(negedge clk); #1;
    check("R3 latency two edges", rdata, 32'hFFFF_FFFF);
    wr(11'h000, 32'hFFFF_FFFF);
    wr(11'h004, 32'hFFFF_FFFF);
    settle();
    rd(11'h184, d); check("R3 active-high only 37", d, 32'h0000_0020);
    rd(11'h180, d); check("R3 active-high w0 idle", d, 0);
    irq_in[37] = 1'b0;
    settle();
    rd(11'h184, d); check("R3 line37 dropped", d, 0);
    wr(11'h041, 32'hFFFF_FFFF);       // misaligned, ignored
    rd(11'h040, d); check("R2 misaligned write", d, 0);
  endtask

  task automatic t_route_mask();
    logic [31:0] d;
    wr(11'h40C, 32'h8000_0002);       // line3 -> pin2
    wr(11'h428, 32'h8000_0004);       // line10 -> pin4
    wr(11'h42C, 32'h4000_0000);       // line11 -> nmi
    wr(11'h430, 32'h2000_0001);       // line12 -> aux, no core flag
    wr(11'h434, 32'h8000_0009);       // line13 -> pin9 (out of range)
    @(negedge clk);
    irq_in[3] = 1; irq_in[10] = 1; irq_in[11] = 1; irq_in[12] = 1; irq_in[13] = 1;
    settle();
    rd(11'h180, d); check("R11 pending while masked", d, 32'h0000_3C08);
    chk_out("R11 masked silent", '0, 0, 0, 0);
    wr(11'h100, 32'h0000_0008);
    rd(11'h140, d); check("R7 set one", d, 32'h0000_0008);
    chk_out("R9 R10 pin2", 6'b000100, 3, 0, 0);
    wr(11'h100, 32'h0000_3C00);
    rd(11'h140, d); check("R7 set more", d, 32'h0000_3C08);
    chk_out("R9 R10 pin4 nmi aux", 6'b010100, 5, 1, 1);
    wr(11'h0C0, 32'h0000_0400);
    rd(11'h140, d); check("R7 clear one", d, 32'h0000_3808);
    chk_out("R10 back to pin2", 6'b000100, 3, 1, 1);
    wr(11'h100, 32'h0);
    rd(11'h140, d); check("R7 zero bits no effect", d, 32'h0000_3808);
    wr(11'h140, 32'hFFFF_FFFF);
    rd(11'h140, d); check("R8 enable array read-only", d, 32'h0000_3808);
    wr(11'h180, 32'h0);
    rd(11'h180, d); check("R8 pending array read-only", d, 32'h0000_3C08);
    wr(11'h438, 32'hFFFF_FFFF);
    rd(11'h438, d); check("R9 route field layout", d, 32'hE000_003F);
    @(negedge clk); irq_in = '0;
    wr(11'h0C0, 32'hFFFF_FFFF);
    settle();
    chk_out("R11 all disabled", '0, 0, 0, 0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(11'h450, 32'h8000_0000);       // line20 -> pin0
    wr(11'h040, 32'h0010_0000);       // line20 edge
    wr(11'h100, 32'h0010_0000);
    settle();
    rd(11'h180, d); check("R4 edge idle", d, 0);
    irq_in[20] = 1'b1; settle();
    rd(11'h180, d); check("R4 rising latched", d, 32'h0010_0000);
    chk_out("R4 pin0 vec1", 6'b000001, 1, 0, 0);
    irq_in[20] = 1'b0; settle();
    rd(11'h180, d); check("R4 latch holds", d, 32'h0010_0000);
    wr(11'h1C0, 32'h0000_0014);       // clear line 20
    rd(11'h180, d); check("R6 clear by number", d, 0);
    chk_out("R6 outputs cleared", '0, 0, 0, 0);
    wr(11'h000, 32'hFFEF_FFFF);       // line20 falling
    irq_in[20] = 1'b1; settle();
    rd(11'h180, d); check("R4 rising ignored pol0", d, 0);
    irq_in[20] = 1'b0; settle();
    rd(11'h180, d); check("R4 falling latched", d, 32'h0010_0000);
    wr(11'h1C0, 32'h0000_0014);
    rd(11'h180, d); check("R6 clear falling", d, 0);
  endtask

  task automatic t_dual();
    logic [31:0] d;
    wr(11'h040, 32'h0030_0000);       // lines 20,21 edge
    wr(11'h080, 32'h0020_0000);       // line21 dual
    irq_in[21] = 1'b1; settle();
    rd(11'h180, d); check("R5 dual rise", d, 32'h0020_0000);
    wr(11'h1C0, 32'h0000_0015);
    rd(11'h180, d); check("R6 dual clear", d, 0);
    irq_in[21] = 1'b0; settle();
    rd(11'h180, d); check("R5 dual fall", d, 32'h0020_0000);
    wr(11'h1C0, 32'h0000_0015);
    rd(11'h180, d); check("R5 dual clear again", d, 0);
  endtask

  task automatic t_sw();
    logic [31:0] d;
    wr(11'h044, 32'h0000_0110);       // lines 36,40 edge
    wr(11'h1C0, 32'h8000_0028);       // set line 40
    rd(11'h184, d); check("R6 software set", d, 32'h0000_0100);
    wr(11'h1C0, 32'h8000_0064);       // number 100: out of range
    rd(11'h184, d); check("R6 out of range w1", d, 32'h0000_0100);
    rd(11'h180, d); check("R6 out of range w0", d, 0);
    wr(11'h1C0, 32'h0000_0028);
    rd(11'h184, d); check("R6 software clear", d, 0);
    rd(11'h1C0, d); check("R6 edge word reads 0", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_level();
    t_route_mask();
    t_edge();
    t_dual();
    t_sw();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule